// File: doc/BRIEF.md
# Bank-Rotating Activate/Read Stress Sequencer

This block produces a DDR3 command stream that keeps every bank busy, for stressing the supply of a memory device or for exercising a read-data model. Once started, it issues a fixed rotation every clock. An ACTIVATE is followed on the next cycle by a READ with auto-precharge. Slots are spaced by the row-to-row activate gap `RRD_CYC`. Four activates fall inside each four-activate window of `FAW_CYC` cycles, and deselect padding fills the rest of the window. Four windows make one pass. The first and third windows address banks 0 to 3, and the second and fourth address banks 4 to 7.

Each slot drives its low address bits and an 8-bit read-data tag with one of two polarities. A plain slot drives all zeros and tag 0x00. A toggled slot drives all ones and tag 0x33. The two polarities alternate from slot to slot. The second half of the pass uses the inverse of the first half. A sub-loop index, a pass counter and an end-of-pass pulse let a bench or a data model follow the schedule. A static configuration-error flag marks timing parameters that cannot hold four activates in one window. When that flag is set, the sequencer never leaves idle.

Top module: `actrd_stress_seq`

## Requirements
- R1: The 4-bit command `{cs_n,ras_n,cas_n,we_n}` has three values. ACTIVATE is 0011, READ with auto-precharge is 0101 with addr[10]=1, and deselect is 1111. A slot's first cycle carries ACTIVATE and its second cycle carries READ. Every other running cycle is a deselect.
- R2: Window w (0..3) of a pass starts at cycle w·FAW_CYC. Slot k (0..3) of that window starts at cycle w·FAW_CYC + k·RRD_CYC and targets bank 4·(w mod 2) + k. The bank value is held for every cycle of the slot.
- R3: From cycle 4·RRD_CYC of a window to the window's last cycle, only deselects are issued, with the bank held at 4·(w mod 2)+3. When FAW_CYC = 4·RRD_CYC there is no padding.
- R4: In windows 0 and 1, slots 0 and 2 are plain: addr[9:0]=0 and rd_tag=0x00. Slots 1 and 3 and the padding are toggled: addr[9:0] all ones and rd_tag=0x33. Address bits above 10 are always 0.
- R5: In windows 2 and 3 the polarity is inverted. Slots 0 and 2 are toggled, while slots 1 and 3 and the padding are plain.
- R6: A pass lasts 4·FAW_CYC cycles. `pass_done` is high only on its last cycle, and the next cycle is an ACTIVATE to bank 0 with sub_idx 0.
- R7: cke is always 1, and odt and dm are always 0.
- R8: Reset is synchronous and active high. From the edge that samples it, and until a start is accepted, outputs are idle: deselect, bank, address, tag, sub_idx and loop_idx all 0, and pass_done 0. `start` is sampled high at edge k. The first ACTIVATE of sub-loop 0 is visible after edge k+1 when REG_OUT=1.
- R9: `start` while the loop is running has no effect on the schedule.
- R10: `cfg_err` is 1 when RRD_CYC < 2 or FAW_CYC < 4·RRD_CYC. With cfg_err set, start is ignored and the outputs stay deselected with sub_idx 0.
- R11: sub_idx = 5·w + k, with k=4 during padding. `loop_idx` counts completed passes modulo 2^LOOP_W and steps on the first cycle of the next pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the looping schedule from idle |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| odt | output | 1 | On-die termination, held low |
| dm | output | 1 | Data mask, held low |
| ba | output | 3 | Bank address |
| addr | output | ADDR_W | Row/column address, bit 10 = auto-precharge on READ |
| rd_tag | output | 8 | Burst pattern tag for a read-data model |
| sub_idx | output | 5 | Sub-loop index 0..19 |
| loop_idx | output | LOOP_W | Completed pass count |
| pass_done | output | 1 | High on the last cycle of each pass |
| cfg_err | output | 1 | Timing parameters are inconsistent |

## Verification
Three instances are run side by side, and each is compared with a model of the schedule on every cycle. The default instance has an RRD of 4 and an FAW of 20, so padding appears in every window. A tight instance has FAW exactly four times RRD. It separates window arithmetic from slot arithmetic and shows that padding vanishes without shifting bank or polarity. A third instance has an impossible timing pair and must stay silent. The run also covers an extra start during a pass, a reset in mid-pass followed by a relaunch, and passes past the first wrap. These separate a correct restart from a drifting counter and first-half polarity from second-half polarity.

// File: rtl/actrd_pkg.sv
package actrd_pkg;

   typedef enum logic [1:0] {
      CMD_DES = 2'd0,
      CMD_ACT = 2'd1,
      CMD_RDA = 2'd2
   } actrd_cmd_e;

   localparam int         SLOTS_PER_WIN = 4;
   localparam int         SUBS_PER_WIN  = SLOTS_PER_WIN + 1;
   localparam int         AP_BIT        = 10;
   localparam logic [2:0] SLOT_PAD      = 3'(SLOTS_PER_WIN);
   localparam logic [7:0] TAG_FLAT      = 8'h00;
   localparam logic [7:0] TAG_TOGGLE    = 8'h33;

   // Everything that leaves the block apart from the pass counter
   typedef struct packed {
      logic          cke;
      logic          cs_n;
      logic          ras_n;
      logic          cas_n;
      logic          we_n;
      logic          odt;
      logic          dm;
      logic [2:0]    ba;
      logic [AP_BIT:0] a_lo;
      logic [7:0]    tag;
      logic [4:0]    sub;
      logic          fin;
   } actrd_bus_t;

   localparam actrd_bus_t BUS_IDLE = '{
      cke: 1'b1, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
      odt: 1'b0, dm: 1'b0, ba: 3'd0, a_lo: '0, tag: 8'h00,
      sub: 5'd0, fin: 1'b0
   };

endpackage

// File: rtl/actrd_timebase.sv
module actrd_timebase
   import actrd_pkg::*;
#(
   parameter int RRD_CYC = 4,
   parameter int FAW_CYC = 20,
   parameter int LOOP_W  = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              hold,
   output logic              run_o,
   output logic [2:0]        slot_o,
   output logic              first_o,
   output logic              second_o,
   output logic [1:0]        win_o,
   output logic              fin_o,
   output logic [LOOP_W-1:0] pass_o
);

   localparam int              PH_W    = (FAW_CYC > 2) ? $clog2(FAW_CYC) : 1;
   localparam int              RP_W    = (RRD_CYC > 2) ? $clog2(RRD_CYC) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(FAW_CYC - 1);
   localparam logic [RP_W-1:0] RP_LAST = RP_W'(RRD_CYC - 1);

   logic              run;
   logic [PH_W-1:0]   ph;
   logic [RP_W-1:0]   rp;
   logic [2:0]        slot;
   logic [1:0]        win;
   logic [LOOP_W-1:0] pass;

   always_ff @(posedge clk) begin
      if (rst) begin
         run  <= 1'b0;
         ph   <= '0;
         rp   <= '0;
         slot <= '0;
         win  <= '0;
         pass <= '0;
      end else if (!run) begin
         if (start && !hold) run <= 1'b1;
      end else if (ph == PH_LAST) begin
         ph   <= '0;
         rp   <= '0;
         slot <= '0;
         win  <= win + 2'd1;
         if (win == 2'd3) pass <= pass + LOOP_W'(1);
      end else begin
         ph <= ph + PH_W'(1);
         if (slot != SLOT_PAD) begin
            if (rp == RP_LAST) begin
               rp   <= '0;
               slot <= slot + 3'd1;
            end else begin
               rp <= rp + RP_W'(1);
            end
         end
      end
   end

   assign run_o    = run;
   assign slot_o   = slot;
   assign first_o  = (rp == RP_W'(0));
   assign second_o = (rp == RP_W'(1));
   assign win_o    = win;
   assign fin_o    = run && (ph == PH_LAST) && (win == 2'd3);
   assign pass_o   = pass;

endmodule

// File: rtl/actrd_decode.sv
module actrd_decode
   import actrd_pkg::*;
(
   input  logic       run,
   input  logic [2:0] slot,
   input  logic       first,
   input  logic       second,
   input  logic [1:0] win,
   input  logic       fin,
   output actrd_bus_t bus
);

   logic       in_slot;
   logic       tog;
   actrd_cmd_e cmd;

   always_comb begin
      bus     = BUS_IDLE;
      in_slot = (slot != SLOT_PAD);
      // padding inherits the polarity of the last slot; upper half inverts
      tog     = (in_slot ? slot[0] : 1'b1) ^ win[1];
      if (!run)                   cmd = CMD_DES;
      else if (in_slot && first)  cmd = CMD_ACT;
      else if (in_slot && second) cmd = CMD_RDA;
      else                        cmd = CMD_DES;
      if (run) begin
         bus.ba   = {win[0], in_slot ? slot[1:0] : 2'b11};
         bus.a_lo = {1'b0, {AP_BIT{tog}}};
         bus.tag  = tog ? TAG_TOGGLE : TAG_FLAT;
         bus.sub  = 5'(win) * 5'(SUBS_PER_WIN) + 5'(slot);
         bus.fin  = fin;
      end
      unique case (cmd)
         CMD_ACT: begin
            bus.cs_n  = 1'b0;
            bus.ras_n = 1'b0;
         end
         CMD_RDA: begin
            bus.cs_n         = 1'b0;
            bus.cas_n        = 1'b0;
            bus.a_lo[AP_BIT] = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/actrd_stress_seq.sv
module actrd_stress_seq
   import actrd_pkg::*;
#(
   parameter int RRD_CYC = 4,
   parameter int FAW_CYC = 20,
   parameter int ADDR_W  = 14,
   parameter int LOOP_W  = 8,
   parameter int REG_OUT = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              odt,
   output logic              dm,
   output logic [2:0]        ba,
   output logic [ADDR_W-1:0] addr,
   output logic [7:0]        rd_tag,
   output logic [4:0]        sub_idx,
   output logic [LOOP_W-1:0] loop_idx,
   output logic              pass_done,
   output logic              cfg_err
);

   localparam bit CFG_BAD = (RRD_CYC < 2) || (FAW_CYC < SLOTS_PER_WIN * RRD_CYC);
   localparam int A_HI    = ADDR_W - AP_BIT - 1;

   if (ADDR_W < AP_BIT + 1) begin : g_chk_aw
      $error("actrd_stress_seq: ADDR_W must cover the auto-precharge bit");
   end
   if (LOOP_W < 1) begin : g_chk_lw
      $error("actrd_stress_seq: LOOP_W must be at least 1");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_chk_ro
      $error("actrd_stress_seq: REG_OUT must be 0 or 1");
   end

   logic              run;
   logic [2:0]        slot;
   logic              first;
   logic              second;
   logic [1:0]        win;
   logic              fin;
   logic [LOOP_W-1:0] pass_cnt;
   actrd_bus_t        d_bus;
   actrd_bus_t        q_bus;
   logic [LOOP_W-1:0] q_loop;

   actrd_timebase #(
      .RRD_CYC (RRD_CYC),
      .FAW_CYC (FAW_CYC),
      .LOOP_W  (LOOP_W)
   ) u_tb (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .hold     (CFG_BAD),
      .run_o    (run),
      .slot_o   (slot),
      .first_o  (first),
      .second_o (second),
      .win_o    (win),
      .fin_o    (fin),
      .pass_o   (pass_cnt)
   );

   actrd_decode u_dec (
      .run    (run),
      .slot   (slot),
      .first  (first),
      .second (second),
      .win    (win),
      .fin    (fin),
      .bus    (d_bus)
   );

   if (REG_OUT != 0) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            q_bus  <= BUS_IDLE;
            q_loop <= '0;
         end else begin
            q_bus  <= d_bus;
            q_loop <= pass_cnt;
         end
      end
   end else begin : g_comb
      assign q_bus  = d_bus;
      assign q_loop = pass_cnt;
   end

   if (A_HI > 0) begin : g_wide
      assign addr = {{A_HI{1'b0}}, q_bus.a_lo};
   end else begin : g_exact
      assign addr = q_bus.a_lo;
   end

   assign cke       = q_bus.cke;
   assign cs_n      = q_bus.cs_n;
   assign ras_n     = q_bus.ras_n;
   assign cas_n     = q_bus.cas_n;
   assign we_n      = q_bus.we_n;
   assign odt       = q_bus.odt;
   assign dm        = q_bus.dm;
   assign ba        = q_bus.ba;
   assign rd_tag    = q_bus.tag;
   assign sub_idx   = q_bus.sub;
   assign pass_done = q_bus.fin;
   assign loop_idx  = q_loop;
   assign cfg_err   = CFG_BAD;

endmodule

// File: rtl/actrd_stress_seq_chk.sv
module actrd_stress_seq_chk #(
   parameter int LOOP_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic              odt,
   input logic              dm,
   input logic [2:0]        ba,
   input logic              ap_bit,
   input logic [7:0]        rd_tag,
   input logic [4:0]        sub_idx,
   input logic [LOOP_W-1:0] loop_idx,
   input logic              pass_done,
   input logic              cfg_err
);

   logic is_act;
   logic is_rda;
   assign is_act = !cs_n && !ras_n && cas_n && we_n;
   assign is_rda = !cs_n && ras_n && !cas_n && we_n;

   a_r1_read_follows_act: assert property (@(posedge clk) disable iff (rst)
      is_act |=> (is_rda && ap_bit && ba == $past(ba)));

   a_r4_tag_on_read: assert property (@(posedge clk) disable iff (rst)
      is_rda |-> (rd_tag == 8'h00 || rd_tag == 8'h33));

   a_r6_wrap_to_bank0: assert property (@(posedge clk) disable iff (rst)
      pass_done |=> (is_act && ba == 3'd0 && sub_idx == 5'd0));

   a_r7_static_levels: assert property (@(posedge clk) disable iff (rst)
      (cke && !odt && !dm));

   a_r8_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (cs_n && sub_idx == 5'd0 && !pass_done));

   a_r10_bad_cfg_silent: assert property (@(posedge clk) disable iff (rst)
      cfg_err |-> (cs_n && sub_idx == 5'd0));

   a_r11_pass_count_step: assert property (@(posedge clk) disable iff (rst)
      pass_done |=> (loop_idx == $past(loop_idx) + LOOP_W'(1)));

endmodule

bind actrd_stress_seq actrd_stress_seq_chk #(.LOOP_W(LOOP_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cke       (cke),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .odt       (odt),
   .dm        (dm),
   .ba        (ba),
   .ap_bit    (addr[10]),
   .rd_tag    (rd_tag),
   .sub_idx   (sub_idx),
   .loop_idx  (loop_idx),
   .pass_done (pass_done),
   .cfg_err   (cfg_err)
);

// File: tb/actrd_stress_seq_tb_top.sv
`timescale 1ns/1ps
module actrd_stress_seq_tb_top;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   always #2.5 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   int n_cur = 0;
   bit finished = 1'b0;

   // default instance: RRD 4, FAW 20
   logic i_cke, i_cs, i_ras, i_cas, i_we, i_odt, i_dm, i_done, i_err;
   logic [2:0] i_ba; logic [13:0] i_addr; logic [7:0] i_tag, i_loop; logic [4:0] i_sub;
   // tight instance: RRD 2, FAW 8
   logic t_cke, t_cs, t_ras, t_cas, t_we, t_odt, t_dm, t_done, t_err;
   logic [2:0] t_ba; logic [13:0] t_addr; logic [7:0] t_tag, t_loop; logic [4:0] t_sub;
   // bad instance: RRD 2, FAW 6
   logic b_cke, b_cs, b_ras, b_cas, b_we, b_odt, b_dm, b_done, b_err;
   logic [2:0] b_ba; logic [13:0] b_addr; logic [7:0] b_tag, b_loop; logic [4:0] b_sub;

   actrd_stress_seq dut_i (
      .clk(clk), .rst(rst), .start(start), .cke(i_cke), .cs_n(i_cs), .ras_n(i_ras),
      .cas_n(i_cas), .we_n(i_we), .odt(i_odt), .dm(i_dm), .ba(i_ba), .addr(i_addr),
      .rd_tag(i_tag), .sub_idx(i_sub), .loop_idx(i_loop), .pass_done(i_done), .cfg_err(i_err));

   actrd_stress_seq #(.RRD_CYC(2), .FAW_CYC(8)) dut_tight (
      .clk(clk), .rst(rst), .start(start), .cke(t_cke), .cs_n(t_cs), .ras_n(t_ras),
      .cas_n(t_cas), .we_n(t_we), .odt(t_odt), .dm(t_dm), .ba(t_ba), .addr(t_addr),
      .rd_tag(t_tag), .sub_idx(t_sub), .loop_idx(t_loop), .pass_done(t_done), .cfg_err(t_err));

   actrd_stress_seq #(.RRD_CYC(2), .FAW_CYC(6)) dut_bad (
      .clk(clk), .rst(rst), .start(start), .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras),
      .cas_n(b_cas), .we_n(b_we), .odt(b_odt), .dm(b_dm), .ba(b_ba), .addr(b_addr),
      .rd_tag(b_tag), .sub_idx(b_sub), .loop_idx(b_loop), .pass_done(b_done), .cfg_err(b_err));

   typedef struct packed {
      logic [3:0]  cmd;
      logic [2:0]  ba;
      logic [13:0] addr;
      logic [7:0]  tag;
      logic [4:0]  sub;
      logic        done;
      logic [7:0]  loop;
      logic        pad;
      logic        upper;
   } exp_t;

   // schedule model written from the requirements
   function automatic exp_t model(int rrd, int faw, int n);
      exp_t e;
      int per = 4 * faw;
      int m   = n % per;
      int w   = m / faw;
      int ph  = m % faw;
      bit in_s = (ph < 4 * rrd);
      int k   = in_s ? ph / rrd : 4;
      int rp  = ph % rrd;
      bit is_a = in_s && (rp == 0);
      bit is_r = in_s && (rp == 1);
      bit tog  = (in_s ? (k % 2 == 1) : 1'b1) ^ (w >= 2);
      e.cmd   = is_a ? 4'b0011 : (is_r ? 4'b0101 : 4'b1111);
      e.ba    = 3'((w % 2) * 4 + (in_s ? k : 3));
      e.addr  = (tog ? 14'h03FF : 14'h0000) | (is_r ? 14'h0400 : 14'h0000);
      e.tag   = tog ? 8'h33 : 8'h00;
      e.sub   = 5'(w * 5 + k);
      e.done  = (m == per - 1);
      e.loop  = 8'((n / per) % 256);
      e.pad   = !in_s;
      e.upper = (w >= 2);
      return e;
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic check_good(input string who, input int rrd, input int faw, input int n,
                             input logic [3:0] c, input logic [2:0] b, input logic [13:0] a,
                             input logic [7:0] t, input logic [4:0] s, input logic d,
                             input logic [7:0] l, input logic [2:0] stat);
      exp_t e = model(rrd, faw, n);
      string where = $sformatf("%s cycle %0d", who, n);
      chk("R1", {where, " cmd"}, c, e.cmd);
      chk(e.pad ? "R3" : "R2", {where, " bank"}, b, e.ba);
      chk(e.upper ? "R5" : "R4", {where, " addr"}, a, e.addr);
      chk(e.upper ? "R5" : "R4", {where, " tag"}, t, e.tag);
      chk("R6", {where, " done"}, d, e.done);
      chk("R11", {where, " sub_idx"}, s, e.sub);
      chk("R11", {where, " loop_idx"}, l, e.loop);
      chk("R7", {where, " cke/odt/dm"}, stat, 3'b100);
   endtask

   task automatic check_bad();
      chk("R10", "dut_bad cfg_err", b_err, 1);
      chk("R10", "dut_bad cs_n", b_cs, 1);
      chk("R10", "dut_bad sub_idx", b_sub, 0);
   endtask

   task automatic check_idle(input string req);
      chk(req, "dut_i idle cmd", {i_cs, i_ras, i_cas, i_we}, 4'b1111);
      chk(req, "dut_i idle bank/addr/tag", {i_ba, i_addr, i_tag}, 0);
      chk(req, "dut_i idle sub/loop/done", {i_sub, i_loop, i_done}, 0);
      chk(req, "dut_tight idle cmd", {t_cs, t_ras, t_cas, t_we}, 4'b1111);
      chk(req, "dut_tight idle sub/loop/done", {t_sub, t_loop, t_done}, 0);
      check_bad();
   endtask

   task automatic step(input string note);
      @(negedge clk);
      check_good({"dut_i", note}, 4, 20, n_cur, {i_cs, i_ras, i_cas, i_we}, i_ba, i_addr,
                 i_tag, i_sub, i_done, i_loop, {i_cke, i_odt, i_dm});
      check_good({"dut_tight", note}, 2, 8, n_cur, {t_cs, t_ras, t_cas, t_we}, t_ba, t_addr,
                 t_tag, t_sub, t_done, t_loop, {t_cke, t_odt, t_dm});
      check_bad();
      n_cur++;
   endtask

   // R8 / R10: state held in and after reset without start
   task automatic t_reset_state();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_idle("R8");
      chk("R10", "dut_i cfg_err", i_err, 0);
      chk("R10", "dut_tight cfg_err", t_err, 0);
      rst = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check_idle("R8");
      end
   endtask

   // R1-R7, R11: launch and follow whole passes; R8 launch latency
   task automatic t_launch(input int cycles);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check_idle("R8");
      n_cur = 0;
      for (int i = 0; i < cycles; i++) step("");
   endtask

   // R9: start pulses in mid-pass must not disturb the schedule
   task automatic t_start_ignored();
      start = 1'b1;
      for (int i = 0; i < 3; i++) step(" R9");
      start = 1'b0;
      for (int i = 0; i < 40; i++) step(" R9");
   endtask

   // R8: reset in mid-pass returns to idle and needs a new start
   task automatic t_midrun_reset();
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check_idle("R8");
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check_idle("R8");
      end
      t_launch(170);
   endtask

   initial begin
      t_reset_state();
      t_launch(170);
      t_start_ignored();
      t_midrun_reset();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule